// File: doc/BRIEF.md
# Reset Release and Bus-Acquire Sequencer

This block brings a bus master out of an external reset in an orderly way. It passes the active-low external reset through a synchronizer. While that reset is low, it records a boot configuration word on each bus-clock enable. The word is a 16-bit data value plus a 3-bit interrupt-level value. The first bus-clock enable that finds the reset released freezes the word and starts a fixed stretch of internal core reset.

Once the stretch is over, the block keeps the bus drivers off until three things hold: the bus is granted, no other master is starting a transfer, and any tenure of another master has been seen to end. It then fires one start pulse that launches reset exception processing and turns the drivers on while the grant is held. If the external reset is asserted again at any time, the whole sequence starts over.

Top module: `boot_bus_seq`

## Requirements
- R1: `ext_rst_n_i` passes through `SYNC_STAGES` (default 2) flops. Asserting it low takes effect at the third rising `clk` edge after the change, and not before.
- R2: While synchronized reset is low, each cycle with `bclk_en_i`=1 loads `cfg_data_i` and `cfg_ipl_i` into the configuration register. The captured value is the one present at the last such enable before release.
- R3: Once `cfg_valid_o` is 1, `cfg_data_o` and `cfg_ipl_o` do not change, whatever the inputs or further enables do.
- R4: `core_rst_o` stays 1 for exactly `HOLD_CYCLES` (default 27) core cycles, counted from the cycle in which `cfg_valid_o` first reads 1.
- R5: While `core_rst_o`=1, `bus_oe_o`=0 and `start_exc_o`=0.
- R6: After the hold, nothing starts and `bus_oe_o` stays 0 while `grant_i`=0. After the start, `bus_oe_o` equals `grant_i`.
- R7: `ts_i`=1 (another master's transfer start, active high) blocks the start and marks a foreign tenure. A 1-to-0 transition of `busy_i` ends that tenure. The start may come no earlier than the edge after the one at which the fall was seen.
- R8: `tenure_end_i`=1 also ends a foreign tenure, with the same one-edge delay before a start is possible.
- R9: `start_exc_o` is a single one-cycle pulse. It rises at the first edge at which hold has ended, `grant_i`=1, `ts_i`=0 and no foreign tenure is pending. No further pulse follows until a new reset.
- R10: A renewed synchronized reset returns the block to the reset state: `core_rst_o`=1, `bus_oe_o`=0 and `cfg_valid_o`=0.
- R11: Release happens only at a `bclk_en_i` cycle. With reset deasserted and no enable, `core_rst_o` stays 1 and `cfg_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset of the block's flops |
| bclk_en_i | input | 1 | One-core-cycle enable marking a rising bus-clock edge |
| ext_rst_n_i | input | 1 | External reset, active low, asynchronous to clk |
| cfg_data_i | input | 16 | Data-bus value sampled as boot configuration |
| cfg_ipl_i | input | 3 | Interrupt-level value sampled as boot configuration |
| grant_i | input | 1 | Bus grant to this master, active high |
| ts_i | input | 1 | Transfer start seen on the bus, active high |
| tenure_end_i | input | 1 | Bus tenure termination from another master, active high |
| busy_i | input | 1 | Bus busy, active high |
| core_rst_o | output | 1 | Internal core reset, active high |
| bus_oe_o | output | 1 | Output enable for the bus drivers (0 = high impedance) |
| cfg_data_o | output | 16 | Captured data-bus configuration |
| cfg_ipl_o | output | 3 | Captured interrupt-level configuration |
| cfg_valid_o | output | 1 | Captured configuration is final |
| start_exc_o | output | 1 | One-cycle pulse starting reset exception processing |

## Verification
The assertions check several rules on every cycle. The drivers stay off during core reset. The start pulse lasts one cycle and only follows a granted, idle bus with no foreign tenure pending. The frozen configuration never moves. The hold counter advances by one each cycle, release coincides with a bus-clock enable, and a synchronized reset always reaches the core reset. Other behaviours are shown only by the bench's scenarios. These are which of several enables supplies the captured word, the exact 27-cycle length, the one-edge latency after a busy fall or a termination, and the three-edge latency of a reassertion.

// File: rtl/boot_bus_pkg.sv
package boot_bus_pkg;
    parameter int unsigned CFG_DATA_W = 16;
    parameter int unsigned CFG_IPL_W  = 3;

    typedef struct packed {
        logic [CFG_DATA_W-1:0] data;
        logic [CFG_IPL_W-1:0]  ipl;
    } boot_cfg_t;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_HOLD  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_t;

    function automatic logic may_start(input seq_state_t st, input logic grant,
                                       input logic ts, input logic foreign);
        return (st == ST_WAIT) && grant && !ts && !foreign;
    endfunction
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_n_async_i,
    output logic rst_low_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= rst_n_async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], rst_n_async_i};
            end
        end
    endgenerate

    assign rst_low_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/boot_cfg_capture.sv
module boot_cfg_capture
    import boot_bus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bclk_en_i,
    input  logic      rst_low_i,
    input  boot_cfg_t sample_i,
    output boot_cfg_t cfg_o
);
    boot_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)                         cfg_q <= '0;
        else if (bclk_en_i && rst_low_i) cfg_q <= sample_i;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/boot_tenure_track.sv
module boot_tenure_track (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic ts_i,
    input  logic tenure_end_i,
    input  logic busy_i,
    output logic foreign_o
);
    logic busy_q;
    logic foreign_q;
    logic end_seen;

    assign end_seen = tenure_end_i || (busy_q && !busy_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            busy_q    <= 1'b0;
            foreign_q <= 1'b0;
        end else begin
            busy_q    <= busy_i;
            foreign_q <= ts_i || (foreign_q && !end_seen);
        end
    end

    assign foreign_o = foreign_q;
endmodule

// File: rtl/boot_bus_seq.sv
module boot_bus_seq
    import boot_bus_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 27,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bclk_en_i,
    input  logic                  ext_rst_n_i,
    input  logic [CFG_DATA_W-1:0] cfg_data_i,
    input  logic [CFG_IPL_W-1:0]  cfg_ipl_i,
    input  logic                  grant_i,
    input  logic                  ts_i,
    input  logic                  tenure_end_i,
    input  logic                  busy_i,
    output logic                  core_rst_o,
    output logic                  bus_oe_o,
    output logic [CFG_DATA_W-1:0] cfg_data_o,
    output logic [CFG_IPL_W-1:0]  cfg_ipl_o,
    output logic                  cfg_valid_o,
    output logic                  start_exc_o
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);

    logic         rst_low;
    logic         foreign;
    boot_cfg_t    sample;
    boot_cfg_t    cfg;
    seq_state_t   state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic         start_q;
    logic         go;

    boot_rst_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .rst_n_async_i(ext_rst_n_i), .rst_low_o(rst_low)
    );

    assign sample = '{data: cfg_data_i, ipl: cfg_ipl_i};

    boot_cfg_capture cap_i (
        .clk(clk), .rst(rst), .bclk_en_i(bclk_en_i), .rst_low_i(rst_low),
        .sample_i(sample), .cfg_o(cfg)
    );

    boot_tenure_track ten_i (
        .clk(clk), .rst(rst), .clear_i(state_q == ST_RESET), .ts_i(ts_i),
        .tenure_end_i(tenure_end_i), .busy_i(busy_i), .foreign_o(foreign)
    );

    assign go = may_start(state_q, grant_i, ts_i, foreign);

    always_comb begin
        state_d = state_q;
        if (rst_low) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET: if (bclk_en_i) state_d = ST_HOLD;
                ST_HOLD:  if (cnt_q == CNT_W'(HOLD_CYCLES - 1)) state_d = ST_WAIT;
                ST_WAIT:  if (go) state_d = ST_RUN;
                ST_RUN:   state_d = ST_RUN;
                default:  state_d = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= !rst_low && go;
            if (state_q == ST_HOLD && state_d == ST_HOLD) cnt_q <= cnt_q + CNT_W'(1);
            else                                          cnt_q <= '0;
        end
    end

    assign core_rst_o  = (state_q == ST_RESET) || (state_q == ST_HOLD);
    assign bus_oe_o    = (state_q == ST_RUN) && grant_i;
    assign cfg_valid_o = (state_q != ST_RESET);
    assign cfg_data_o  = cfg.data;
    assign cfg_ipl_o   = cfg.ipl;
    assign start_exc_o = start_q;

    AST_SYNC_REACHES_CORE: assert property (@(posedge clk) disable iff (rst)
        rst_low |=> core_rst_o && !cfg_valid_o); // R10
    AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |-> !bus_oe_o && !start_exc_o); // R5
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        start_exc_o |=> !start_exc_o); // R9
    AST_START_GRANTED: assert property (@(posedge clk) disable iff (rst)
        start_exc_o |-> $past(grant_i) && !$past(ts_i)); // R6
    AST_START_NO_OWNER: assert property (@(posedge clk) disable iff (rst)
        start_exc_o |-> !$past(foreign)); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_valid_o && $past(cfg_valid_o) |-> $stable(cfg_data_o) && $stable(cfg_ipl_o)); // R3
    AST_RELEASE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid_o) |-> $past(bclk_en_i)); // R11
    AST_HOLD_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R4
endmodule

// File: tb/boot_bus_seq_tb_top.sv
`timescale 1ns/1ps
module boot_bus_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk_en = 1'b0, ext_rst_n = 1'b0;
    logic [15:0] data_in = '0;
    logic [2:0]  ipl_in = '0;
    logic grant = 1'b0, ts = 1'b0, tend = 1'b0, busy = 1'b0;
    logic core_rst, oe, valid, start;
    logic [15:0] cfg_data;
    logic [2:0]  cfg_ipl;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    boot_bus_seq dut_i (
        .clk(clk), .rst(rst), .bclk_en_i(bclk_en), .ext_rst_n_i(ext_rst_n),
        .cfg_data_i(data_in), .cfg_ipl_i(ipl_in), .grant_i(grant), .ts_i(ts),
        .tenure_end_i(tend), .busy_i(busy), .core_rst_o(core_rst), .bus_oe_o(oe),
        .cfg_data_o(cfg_data), .cfg_ipl_o(cfg_ipl), .cfg_valid_o(valid),
        .start_exc_o(start)
    );

    // bits: grant, ts, tenure_end, busy, expected start, expected oe
    localparam logic [5:0] VEC [0:8] = '{
        6'b0000_00, 6'b1101_00, 6'b1001_00, 6'b1001_00, 6'b1000_00,
        6'b1000_11, 6'b1000_01, 6'b0000_00, 6'b1000_01
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_bclk();
        bclk_en = 1'b1;
        tick();
        bclk_en = 1'b0;
    endtask

    task automatic release_and_hold(output int n, output int bad);
        n = 0; bad = 0;
        ext_rst_n = 1'b1;
        repeat (4) tick();
        check("R11 no release without enable", {30'd0, core_rst, valid}, 32'd2);
        pulse_bclk();
        while (core_rst && n < 100) begin
            n++;
            if (oe || start) bad++;
            bclk_en = (n % 4 == 0);
            data_in = 16'(n);
            tick();
        end
        bclk_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n, bad, cnt;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R5 reset state", {28'd0, core_rst, oe, valid, start}, 32'h8);

        // R2: two captures while low, last one must win
        data_in = 16'h1234; ipl_in = 3'd2; pulse_bclk();
        data_in = 16'hBEEF; ipl_in = 3'd5; pulse_bclk();
        data_in = 16'h0F0F; ipl_in = 3'd7;
        check("R11 valid low during reset", {31'd0, valid}, 32'd0);
        release_and_hold(n, bad);
        check("R4 hold length", n, 27);
        check("R5 no drive during hold", bad, 0);
        check("R2 captured data", {16'd0, cfg_data}, 32'hBEEF);
        check("R2 captured ipl", {29'd0, cfg_ipl}, 32'd5);
        check("R3 frozen after enables", {31'd0, valid}, 32'd1);

        // R6 R7 R9: acquisition table
        for (int i = 0; i < 9; i++) begin
            {grant, ts, tend, busy} = VEC[i][5:2];
            tick();
            check($sformatf("R7/R9 vector %0d", i), {30'd0, start, oe}, {30'd0, VEC[i][1:0]});
        end

        // R1 R10: reassert external reset
        ext_rst_n = 1'b0;
        tick(); tick();
        check("R1 not yet reset after two edges", {31'd0, oe}, 32'd1);
        tick();
        check("R10 reset restarts", {29'd0, core_rst, oe, valid}, 32'h4);

        // R8: tenure end by termination input
        grant = 1'b0; ts = 1'b0; tend = 1'b0; busy = 1'b0;
        data_in = 16'hA5A5; ipl_in = 3'd3; pulse_bclk();
        release_and_hold(n, bad);
        check("R4 hold length second run", n, 27);
        check("R3 new capture frozen", {13'd0, cfg_data, cfg_ipl}, {13'd0, 16'hA5A5, 3'd3});
        grant = 1'b1; ts = 1'b1; tick();
        check("R7 ts blocks start", {31'd0, start}, 32'd0);
        ts = 1'b0; tick();
        check("R8 tenure pending", {31'd0, start}, 32'd0);
        tend = 1'b1; tick();
        check("R8 end seen same edge no start", {31'd0, start}, 32'd0);
        tend = 1'b0; tick();
        check("R8 start after termination", {30'd0, start, oe}, 32'd3);

        // R9: immediate start at hold expiry, then no further pulse
        ext_rst_n = 1'b0; repeat (3) tick();
        pulse_bclk();
        release_and_hold(n, bad);
        check("R5 no start while granted in hold", bad, 0);
        check("R9 no start at first wait cycle", {31'd0, start}, 32'd0);
        tick();
        check("R9 start at expiry", {30'd0, start, oe}, 32'd3);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (start) cnt++;
        end
        check("R9 single pulse", cnt, 0);
        grant = 1'b0; #1;
        check("R6 oe follows grant", {31'd0, oe}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule